// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host end of a four-wire in-system programming link. It drives the target's reset line, the serial clock and the host-to-target data line, and it samples the target-to-host data line. The rest of the chip gives it one command at a time on a valid/ready request port. The commands are: open a session, erase the chip, stream a page of program words from a small local buffer, commit the page, read back one byte, and close the session. Each command ends with a one-cycle `done` pulse. A failed session entry also raises `err`, and a read also updates `rdata`.

Every instruction is 32 bits long and goes through one shared shifter. The shifter builds the serial clock from a configurable count of clock cycles for each half-period. It changes the outgoing bit only while the serial clock is low, and it takes the incoming bit at the moment the clock falls.

Entering a session works as follows. The sequencer pulses reset high, holds it low for a long settle time and then sends the enable instruction. It checks the third returned byte against the sync value. On a mismatch it pulses reset again and retries, up to a limit. After an erase or a page commit the link stays quiet for a fixed write time. The page load always sends the low byte of a word before its high byte.

The control FSM has these states: `ST_IDLE`, `ST_RST_PULSE`, `ST_SETTLE`, `ST_SHIFT`, `ST_POSTWR` and `ST_FINISH`.

- `ST_IDLE` goes to `ST_RST_PULSE` on an enter request, to `ST_FINISH` on a close request or an unknown code, and to `ST_SHIFT` for every other request.
- `ST_RST_PULSE` goes to `ST_SETTLE` when its timer expires.
- `ST_SETTLE` goes to `ST_SHIFT` when its timer expires.
- `ST_SHIFT` stays in `ST_SHIFT` between the words of a page load. It goes to `ST_RST_PULSE` on a bad echo while retries remain, to `ST_POSTWR` after an erase or a commit, and to `ST_FINISH` otherwise.
- `ST_POSTWR` goes to `ST_FINISH` when its timer expires.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `isp_host_seq`

## Requirements
- R1: After reset, `tgt_rst` and `sck` are 0, `req_ready` is 1 and `done` is 0.
- R2: An enter command (`req_op`=0) first drives `tgt_rst` high for exactly T_RSTP cycles. It then holds `tgt_rst` low for at least T_SETTLE cycles before the first rising edge of `sck`.
- R3: Each `sck` low phase and each `sck` high phase lasts at least HALF cycles, and `mosi` does not change while `sck` is high.
- R4: An instruction is 32 `sck` pulses. Outgoing bits go MSB first. Incoming bits are sampled as `sck` falls, MSB first, so the fourth returned byte is the last eight bits.
- R5: The enable instruction is 0xAC530000. When the third returned byte is 0x53, the command finishes with `done` and no `err` after one attempt.
- R6: When the third returned byte differs, all 32 bits are still sent, reset is pulsed again and the enable is resent. After MAX_TRIES failed attempts, `done` and `err` pulse together.
- R7: A page load (`req_op`=2) sends two instructions for each buffer word, in word order 0 to PAGE_WORDS-1. The low-byte instruction {0x40, 0x00, word offset, data[7:0]} always comes before the high-byte instruction {0x48, 0x00, word offset, data[15:8]}.
- R8: A page commit (`req_op`=3) sends {0x4C, address[15:8], address[7:0], 0x00}, with the word-offset bits of the address cleared. `sck` then stays low for at least T_WRITE cycles before `done`.
- R9: An erase (`req_op`=1) sends 0xAC800000. `sck` then stays low for at least T_WRITE cycles before `done`.
- R10: A read (`req_op`=4) sends {0x20, or 0x28 when `req_hi` is set, address[15:8], address[7:0], 0x00}. The fourth returned byte appears on `rdata` when `done` pulses.
- R11: A close command (`req_op`=5) drives `tgt_rst` high with no `sck` activity and finishes with `done`.
- R12: `sck` is never high while `tgt_rst` is high.
- R13: `done` lasts one cycle, and `req_ready` is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request, taken when `req_ready` is high |
| req_op | input | 3 | Command code: 0 enter, 1 erase, 2 page load, 3 page commit, 4 read, 5 close |
| req_addr | input | ADDR_W | Word address for commit and read |
| req_hi | input | 1 | Read selects the high byte of the word |
| req_ready | output | 1 | Sequencer is idle |
| buf_we | input | 1 | Write strobe for the local page buffer |
| buf_idx | input | log2(PAGE_WORDS) | Buffer word index |
| buf_data | input | 16 | Buffer word data |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Entry failed, valid with `done` |
| rdata | output | 8 | Last byte read back |
| tgt_rst | output | 1 | Target reset line |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |

## Verification
Entry is run three times against a target model:

- with a clean echo,
- with two corrupted echoes,
- with echoes that stay corrupted.

These runs separate a correct match from a dropped retry, an off-by-one attempt limit and an error that arrives too early. A page load is filled with a distinct pattern in every word's two bytes, which exposes swapped halves, a wrong load order or a wrong offset. Reads of the low byte and the high byte use different return values and different addresses. This shows whether the selector bit, the address bytes and the capture of the fourth byte are correct. Erase and commit are each timed from the last clock fall to `done`.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [2:0] {
        OP_ENTER = 3'd0,
        OP_ERASE = 3'd1,
        OP_LOAD  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4,
        OP_EXIT  = 3'd5
    } isp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_PULSE,
        ST_SETTLE,
        ST_SHIFT,
        ST_POSTWR,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] B_PREFIX = 8'hAC;
    localparam logic [7:0] B_SYNC   = 8'h53;
    localparam logic [7:0] B_ERASE  = 8'h80;
    localparam logic [7:0] B_LOADPG = 8'h40;
    localparam logic [7:0] B_WRPG   = 8'h4C;
    localparam logic [7:0] B_RDPG   = 8'h20;
    localparam logic [7:0] B_HISEL  = 8'h08;

endpackage

// File: rtl/isp_page_buf.sv
module isp_page_buf #(
    parameter int WORDS = 16,
    parameter int DW    = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/isp_xfer.sv
module isp_xfer #(
    parameter int HALF = 3,
    localparam int CW  = $clog2(HALF + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] tx,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx
);
    typedef enum logic [1:0] {XS_IDLE, XS_LOW, XS_HIGH} xs_e;

    xs_e         xs_q, xs_nx;
    logic [CW-1:0] cnt_q;
    logic [4:0]  bit_q;
    logic [31:0] sr_q;
    logic        half_end;

    assign half_end = (cnt_q == CW'(HALF - 1));

    always_comb begin
        xs_nx = xs_q;
        unique case (xs_q)
            XS_IDLE:  if (start) xs_nx = XS_LOW;
            XS_LOW:   if (half_end) xs_nx = XS_HIGH;
            XS_HIGH:  if (half_end) xs_nx = (bit_q == 5'd31) ? XS_IDLE : XS_LOW;
            default:  xs_nx = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xs_q <= XS_IDLE;
        else        xs_q <= xs_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            sr_q  <= '0;
            sck   <= 1'b0;
            done  <= 1'b0;
            rx    <= '0;
        end else begin
            done <= 1'b0;
            unique case (xs_q)
                XS_IDLE: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                    if (start) sr_q <= tx;
                end
                XS_LOW: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        sck   <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                XS_HIGH: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        sck   <= 1'b0;
                        rx    <= {rx[14:0], miso};
                        sr_q  <= {sr_q[30:0], 1'b0};
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == 5'd31) done <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign mosi = sr_q[31];
    assign busy = (xs_q != XS_IDLE);

    // Phase-length checkers
    logic [15:0] hi_run, lo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sck ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : 16'd0;
            lo_run <= !sck ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : 16'd0;
        end
    end

    assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> (hi_run >= 16'(HALF)));
    assert_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> (lo_run >= 16'(HALF)));
    assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
    import isp_pkg::*;
#(
    parameter int HALF       = 3,
    parameter int T_RSTP     = 8,
    parameter int T_SETTLE   = 4_000_000,
    parameter int T_WRITE    = 900_000,
    parameter int MAX_TRIES  = 4,
    parameter int PAGE_WORDS = 16,
    parameter int ADDR_W     = 10,
    localparam int WW        = $clog2(PAGE_WORDS),
    localparam int TW        = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hi,
    output logic              req_ready,
    input  logic              buf_we,
    input  logic [WW-1:0]     buf_idx,
    input  logic [15:0]       buf_data,
    output logic              done,
    output logic              err,
    output logic [7:0]        rdata,
    output logic              tgt_rst,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    seq_state_e        state_q, state_nx;
    isp_op_e           op_q, op_in;
    logic [ADDR_W-1:0] addr_q;
    logic              hi_q, h_q, kick_q;
    logic [WW-1:0]     w_q;
    logic [TW-1:0]     tries_q;
    logic [31:0]       cnt_q;
    logic [31:0]       tx_word;
    logic [15:0]       bd, wa, pa;
    logic              x_busy, x_done, echo_ok, last_try, t_zero;
    logic [15:0]       x_rx;

    assign op_in    = isp_op_e'(req_op);
    assign echo_ok  = (x_rx[15:8] == B_SYNC);
    assign last_try = (tries_q == TW'(MAX_TRIES - 1));
    assign t_zero   = (cnt_q == 32'd0);

    isp_page_buf #(.WORDS(PAGE_WORDS), .DW(16)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(buf_data),
        .ridx(w_q), .rdata(bd)
    );

    isp_xfer #(.HALF(HALF)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(kick_q), .tx(tx_word), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(x_busy), .done(x_done), .rx(x_rx)
    );

    // Instruction builder
    assign wa = 16'(addr_q);
    assign pa = wa & ~16'(PAGE_WORDS - 1);
    always_comb begin
        unique case (op_q)
            OP_ENTER: tx_word = {B_PREFIX, B_SYNC, 16'h0000};
            OP_ERASE: tx_word = {B_PREFIX, B_ERASE, 16'h0000};
            OP_LOAD:  tx_word = {B_LOADPG | (h_q ? B_HISEL : 8'h00), 8'h00, 8'(w_q),
                                 h_q ? bd[15:8] : bd[7:0]};
            OP_WRITE: tx_word = {B_WRPG, pa, 8'h00};
            OP_READ:  tx_word = {B_RDPG | (hi_q ? B_HISEL : 8'h00), wa, 8'h00};
            default:  tx_word = 32'h0;
        endcase
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (op_in == OP_ENTER) state_nx = ST_RST_PULSE;
                else if (op_in == OP_ERASE || op_in == OP_LOAD ||
                         op_in == OP_WRITE || op_in == OP_READ) state_nx = ST_SHIFT;
                else state_nx = ST_FINISH;
            end
            ST_RST_PULSE: if (t_zero) state_nx = ST_SETTLE;
            ST_SETTLE:    if (t_zero) state_nx = ST_SHIFT;
            ST_SHIFT: if (x_done) begin
                case (op_q)
                    OP_ENTER: state_nx = (echo_ok || last_try) ? ST_FINISH : ST_RST_PULSE;
                    OP_ERASE, OP_WRITE: state_nx = ST_POSTWR;
                    OP_LOAD: state_nx = (h_q && w_q == WW'(PAGE_WORDS - 1)) ? ST_FINISH : ST_SHIFT;
                    default: state_nx = ST_FINISH;
                endcase
            end
            ST_POSTWR: if (t_zero) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_ENTER; addr_q <= '0; hi_q <= 1'b0; h_q <= 1'b0;
            w_q <= '0; tries_q <= '0; cnt_q <= '0; kick_q <= 1'b0;
            done <= 1'b0; err <= 1'b0; rdata <= '0; tgt_rst <= 1'b0;
        end else begin
            done   <= (state_nx == ST_FINISH);
            kick_q <= (state_nx == ST_SHIFT) && (state_q != ST_SHIFT || x_done);
            err    <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q <= op_in; addr_q <= req_addr; hi_q <= req_hi;
                    tries_q <= '0; w_q <= '0; h_q <= 1'b0;
                    if (op_in == OP_ENTER) begin
                        tgt_rst <= 1'b1;
                        cnt_q   <= 32'(T_RSTP - 1);
                    end else if (op_in == OP_EXIT) tgt_rst <= 1'b1;
                end
                ST_RST_PULSE: if (t_zero) begin
                    tgt_rst <= 1'b0;
                    cnt_q   <= 32'(T_SETTLE - 1);
                end else cnt_q <= cnt_q - 1'b1;
                ST_SETTLE: if (!t_zero) cnt_q <= cnt_q - 1'b1;
                ST_SHIFT: if (x_done) begin
                    case (op_q)
                        OP_ENTER: if (!echo_ok) begin
                            tries_q <= tries_q + 1'b1;
                            if (last_try) err <= 1'b1;
                            else begin
                                tgt_rst <= 1'b1;
                                cnt_q   <= 32'(T_RSTP - 1);
                            end
                        end
                        OP_ERASE, OP_WRITE: cnt_q <= 32'(T_WRITE - 1);
                        OP_LOAD: begin
                            h_q <= !h_q;
                            if (h_q) w_q <= w_q + 1'b1;
                        end
                        OP_READ: rdata <= x_rx[7:0];
                        default: ;
                    endcase
                end
                ST_POSTWR: if (!t_zero) cnt_q <= cnt_q - 1'b1;
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);

    assert_sck_in_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !tgt_rst);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    assert_quiet_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POSTWR) |-> (!sck && !x_busy));
    assert_no_shift_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE || state_q == ST_RST_PULSE) |-> !x_busy);
endmodule

// File: tb/test_isp_host_seq.sv
module test_isp_host_seq;
    import isp_pkg::*;

    localparam int HALF = 3, T_RSTP = 5, T_SETTLE = 40, T_WRITE = 30;
    localparam int MAX_TRIES = 3, PAGE_WORDS = 16, ADDR_W = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_hi = 1'b0, buf_we = 1'b0;
    logic [2:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0] buf_idx = '0;
    logic [15:0] buf_data = '0;
    logic req_ready, done, err, tgt_rst, sck, mosi, miso;
    logic [7:0] rdata;

    always #2.5 clk = ~clk;

    isp_host_seq #(.HALF(HALF), .T_RSTP(T_RSTP), .T_SETTLE(T_SETTLE), .T_WRITE(T_WRITE),
                   .MAX_TRIES(MAX_TRIES), .PAGE_WORDS(PAGE_WORDS), .ADDR_W(ADDR_W)) i_isp_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_hi(req_hi), .req_ready(req_ready), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .done(done), .err(err), .rdata(rdata), .tgt_rst(tgt_rst),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    int n_cmp = 0, n_bad = 0;
    bit fin = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Scoreboard of expected instruction words
    logic [31:0] exp_q[$];
    task automatic push_exp(input logic [31:0] w);
        exp_q.push_back(w);
    endtask

    // Target model
    logic [4:0]  t_idx = '0, r_cnt = '0;
    logic [31:0] r_word = '0;
    logic [7:0]  rb0 = '0, rb1 = '0, resp = '0, echo3;
    int enables_seen = 0, corrupt_until = 0;

    always @(posedge sck) begin
        r_word = {r_word[30:0], mosi};
        if (r_cnt == 5'd7)  rb0 = r_word[7:0];
        if (r_cnt == 5'd15) rb1 = r_word[7:0];
        if (r_cnt == 5'd31) begin
            if (exp_q.size() == 0) check(1'b0, "R4", "unexpected instruction", r_word, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(r_word == e, "R4", "instruction word", r_word, e);
            end
            if (r_word[31:16] == 16'hAC53) enables_seen++;
        end
        r_cnt = r_cnt + 5'd1;
    end

    always @(negedge sck) t_idx = t_idx + 5'd1;

    always_comb begin
        echo3 = (enables_seen < corrupt_until) ? ~rb1 : rb1;
        case (t_idx[4:3])
            2'd0:    miso = 1'b0;
            2'd1:    miso = rb0[3'(7 - t_idx[2:0])];
            2'd2:    miso = echo3[3'(7 - t_idx[2:0])];
            default: miso = resp[3'(7 - t_idx[2:0])];
        endcase
    end

    // Line monitor
    int cyc = 0, rst_run = 0, last_rst_len = 0, rst_pulses = 0, rst_fall_cyc = 0;
    int min_gap = 1000000, last_fall_cyc = 0, overlap = 0, sck_rises = 0;
    bit armed = 1'b0, sck_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (tgt_rst) rst_run++;
        else begin
            if (rst_run != 0) begin
                last_rst_len = rst_run; rst_fall_cyc = cyc; rst_pulses++; armed = 1'b1;
            end
            rst_run = 0;
        end
        if (sck && !sck_prev) begin
            sck_rises++;
            if (armed) begin
                if (cyc - rst_fall_cyc < min_gap) min_gap = cyc - rst_fall_cyc;
                armed = 1'b0;
            end
        end
        if (!sck && sck_prev) last_fall_cyc = cyc;
        if (sck && tgt_rst) overlap++;
        sck_prev = sck;
    end

    logic got_err;
    logic [7:0] got_rdata;
    int done_cyc;

    task automatic run_op(input logic [2:0] op, input logic [9:0] a, input logic h);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_hi = h;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_err = err; got_rdata = rdata; done_cyc = cyc;
        @(negedge clk);
        check(!done && req_ready, "R13", "done one cycle then ready", {done, req_ready}, 2'b01);
    endtask

    function automatic logic [15:0] pat(input int i);
        return {4'(i) ^ 4'h5, 4'h3, 8'(i * 37 + 1)};
    endfunction

    initial begin
        int p0, e0;
        repeat (3) @(negedge clk);
        check(tgt_rst == 0 && sck == 0, "R1", "reset lines", {tgt_rst, sck}, 0);
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        check(done == 0, "R1", "done after reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tgt_rst == 0 && sck == 0 && req_ready, "R1", "idle after release", {tgt_rst, sck, req_ready}, 1);

        // Clean entry
        push_exp(32'hAC530000);
        run_op(OP_ENTER, '0, 0);
        check(got_err == 0, "R5", "clean entry err", got_err, 0);
        check(enables_seen == 1, "R5", "single enable", enables_seen, 1);
        check(rst_pulses == 1, "R2", "reset pulses", rst_pulses, 1);
        check(last_rst_len == T_RSTP, "R2", "reset pulse width", last_rst_len, T_RSTP);
        check(min_gap >= T_SETTLE, "R2", "settle gap", min_gap, T_SETTLE);

        // Two bad echoes, then good
        p0 = rst_pulses; e0 = enables_seen;
        corrupt_until = enables_seen + 2;
        repeat (3) push_exp(32'hAC530000);
        run_op(OP_ENTER, '0, 0);
        check(got_err == 0, "R6", "recovered entry err", got_err, 0);
        check(enables_seen - e0 == 3, "R6", "enables on retry", enables_seen - e0, 3);
        check(rst_pulses - p0 == 3, "R6", "pulses on retry", rst_pulses - p0, 3);

        // Always bad
        p0 = rst_pulses; e0 = enables_seen;
        corrupt_until = enables_seen + 100;
        repeat (MAX_TRIES) push_exp(32'hAC530000);
        run_op(OP_ENTER, '0, 0);
        check(got_err == 1, "R6", "failed entry err", got_err, 1);
        check(enables_seen - e0 == MAX_TRIES, "R6", "attempt limit", enables_seen - e0, MAX_TRIES);
        corrupt_until = 0;
        check(min_gap >= T_SETTLE, "R2", "settle gap on retries", min_gap, T_SETTLE);

        // Erase
        push_exp(32'hAC800000);
        run_op(OP_ERASE, '0, 0);
        check(done_cyc - last_fall_cyc >= T_WRITE, "R9", "erase wait", done_cyc - last_fall_cyc, T_WRITE);

        // Page load
        for (int i = 0; i < PAGE_WORDS; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_idx = 4'(i); buf_data = pat(i);
        end
        @(negedge clk);
        buf_we = 1'b0;
        for (int i = 0; i < PAGE_WORDS; i++) begin
            logic [15:0] d;
            d = pat(i);
            push_exp({8'h40, 8'h00, 8'(i), d[7:0]});   // R7 low first
            push_exp({8'h48, 8'h00, 8'(i), d[15:8]});  // R7 high second
        end
        run_op(OP_LOAD, '0, 0);
        check(exp_q.size() == 0, "R7", "all load words sent", exp_q.size(), 0);

        // Page commit
        push_exp(32'h4C02A000);
        run_op(OP_WRITE, 10'h2A7, 0);
        check(done_cyc - last_fall_cyc >= T_WRITE, "R8", "commit wait", done_cyc - last_fall_cyc, T_WRITE);

        // Reads
        resp = 8'h5A;
        push_exp(32'h20013500);
        run_op(OP_READ, 10'h135, 0);
        check(got_rdata == 8'h5A, "R10", "read low byte", got_rdata, 8'h5A);
        resp = 8'hC3;
        push_exp(32'h2803FF00);
        run_op(OP_READ, 10'h3FF, 1);
        check(got_rdata == 8'hC3, "R10", "read high byte", got_rdata, 8'hC3);

        // Close
        e0 = sck_rises;
        run_op(OP_EXIT, '0, 0);
        check(tgt_rst == 1, "R11", "reset high after close", tgt_rst, 1);
        check(sck_rises == e0, "R11", "no clock on close", sck_rises, e0);
        check(overlap == 0, "R12", "clock while in reset", overlap, 0);
        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            check(1'b0, "R13", "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule